// File: doc/BRIEF.md
# Linked-Structure Pointer Validator

This block decides whether a 64-bit pointer to a secondary control structure may be accepted before an entry goes ahead. A one-cycle start strobe captures the pointer and its context: the pointer of the structure now in use, the expected 32-bit revision identifier, an 8-bit physical-address width, a wide-address-mode select and two system-management-mode flags. The block then runs its format checks in a fixed priority order. If they all pass, it issues one 32-bit read at the pointer address and compares the returned word with the revision identifier.

An all-ones pointer means "no linked structure". That value skips every check and is accepted at once, with no memory traffic. Any format failure also ends the check without a memory request. The block returns its verdict as a one-cycle done pulse, together with a pass flag and a 3-bit cause code. The pass flag and cause code stay stable until the next accepted start.

Top module: `link_ptr_validator`

## Requirements
- R1: A captured pointer of all ones gives pass=1 and cause 0, with no memory request. Done rises on the second falling clock edge after the start edge.
- R2: A pointer with any of bits 11:0 set gives pass=0 and cause 1 (misaligned), with no memory request. Done follows on the second cycle after start.
- R3: In wide mode (wideMode=1), any pointer bit at or above the physical-address width gives cause 2, with no request. A width value above 64 is treated as 64, so no bit is then out of range.
- R4: In narrow mode (wideMode=0), any set bit in 63:32 gives cause 2, with no request, whatever the width input holds.
- R5: When inSmm=0 or entrySmm=1, a pointer equal to the current-structure pointer gives cause 3. When inSmm=1 and entrySmm=0, equality is allowed.
- R6: When several format checks fail at once, the cause reported follows the order misaligned (1), then too wide (2), then equal to the current pointer (3).
- R7: When every format check passes, exactly one read request is issued, at the captured pointer address. memReqValid and memReqAddr hold steady until memReqReady accepts the request.
- R8: A response word equal to the revision identifier gives pass=1 and cause 0. Any other word gives pass=0 and cause 4.
- R9: A response with memRspErr=1 gives pass=0 and cause 5, whatever the data.
- R10: Done is high for exactly one cycle per check. While done is high, pass equals (cause==0). Pass and cause then hold until the next accepted start.
- R11: A start strobe that arrives while a check is in progress is ignored. It does not change the request address or the verdict, and it does not begin a second check.
- R12: After reset, done, pass, memReqValid and cause are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled only when idle |
| linkPtr | input | 64 | Pointer under test |
| curPtr | input | 64 | Pointer of the structure now in use |
| revId | input | 32 | Expected revision identifier |
| paWidth | input | 8 | Physical-address width in bits |
| wideMode | input | 1 | 1: width-based range check, 0: 32-bit range check |
| inSmm | input | 1 | Currently in system-management mode |
| entrySmm | input | 1 | Entry targets system-management mode |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 64 | Read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |
| memRspErr | input | 1 | Read response error |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Pointer accepted |
| cause | output | 3 | Result code: 0 pass, 1 misaligned, 2 too wide, 3 equals current, 4 revision mismatch, 5 memory error |

## Verification
A control state stuck in or skipping a step shows up within a few cycles. Done arrives late or never, a read request appears for a pointer that fails a format check, or the sentinel produces memory traffic. A corrupted captured pointer or width register shows up at the end of the same check, either as a wrong request address or as a wrong cause code. Format-only outcomes are expected exactly two cycles after start, so a latency error in that path is caught at once.

// File: rtl/lpv_pkg.sv
`timescale 1ns/1ps
package lpv_pkg;

  typedef enum logic [2:0] {
    CAUSE_OK      = 3'd0,
    CAUSE_MISALIGN = 3'd1,
    CAUSE_WIDE    = 3'd2,
    CAUSE_SELF    = 3'd3,
    CAUSE_REV     = 3'd4,
    CAUSE_MEMERR  = 3'd5
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   setResult;
    cause_e code;
  } ctrl_s;

  // conditions from datapath to control
  typedef struct packed {
    logic sentinel;
    logic misaligned;
    logic tooWide;
    logic selfRef;
    logic revMatch;
  } flags_s;

endpackage

// File: rtl/lpv_datapath.sv
`timescale 1ns/1ps
module lpv_datapath
  import lpv_pkg::*;
#(
  parameter int PTR_W      = 64,
  parameter int REV_W      = 32,
  parameter int PAW_W      = 8,
  parameter int ALIGN_BITS = 12,
  parameter int NARROW_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            ctrl,
  input  logic [PTR_W-1:0] linkPtr,
  input  logic [PTR_W-1:0] curPtr,
  input  logic [REV_W-1:0] revId,
  input  logic [PAW_W-1:0] paWidth,
  input  logic             wideMode,
  input  logic             inSmm,
  input  logic             entrySmm,
  input  logic [REV_W-1:0] memRspData,
  output flags_s           flags,
  output logic [PTR_W-1:0] memReqAddr,
  output logic             pass,
  output logic [2:0]       cause
);

  localparam int CLAMP_W = $clog2(PTR_W + 1);
  localparam logic [PTR_W-1:0] ALIGN_MASK  = ~({PTR_W{1'b1}} << ALIGN_BITS);
  localparam logic [PTR_W-1:0] NARROW_MASK = {PTR_W{1'b1}} << NARROW_W;

  logic [PTR_W-1:0]   ptrQ;
  logic [PTR_W-1:0]   curQ;
  logic [REV_W-1:0]   revQ;
  logic [CLAMP_W-1:0] paQ;
  logic               wideQ;
  logic               selfRuleQ;
  logic [CLAMP_W-1:0] paClamped;
  logic [PTR_W-1:0]   wideMask;
  logic [PTR_W-1:0]   rangeMask;
  logic               passQ;
  cause_e             causeQ;

  // width above the pointer size means every bit is in range
  always_comb begin
    if (paWidth > PAW_W'(PTR_W)) paClamped = CLAMP_W'(PTR_W);
    else                         paClamped = CLAMP_W'(paWidth);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ      <= '0;
      curQ      <= '0;
      revQ      <= '0;
      paQ       <= '0;
      wideQ     <= 1'b0;
      selfRuleQ <= 1'b0;
    end else if (ctrl.capture) begin
      ptrQ      <= linkPtr;
      curQ      <= curPtr;
      revQ      <= revId;
      paQ       <= paClamped;
      wideQ     <= wideMode;
      selfRuleQ <= !inSmm || entrySmm;
    end
  end

  // bits at or above the captured width are out of range
  for (genvar i = 0; i < PTR_W; i++) begin : g_mask
    assign wideMask[i] = (CLAMP_W'(i) >= paQ);
  end

  assign rangeMask = wideQ ? wideMask : NARROW_MASK;

  assign flags.sentinel   = &ptrQ;
  assign flags.misaligned = |(ptrQ & ALIGN_MASK);
  assign flags.tooWide    = |(ptrQ & rangeMask);
  assign flags.selfRef    = selfRuleQ && (ptrQ == curQ);
  assign flags.revMatch   = (memRspData == revQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passQ  <= 1'b0;
      causeQ <= CAUSE_OK;
    end else if (ctrl.setResult) begin
      passQ  <= (ctrl.code == CAUSE_OK);
      causeQ <= ctrl.code;
    end
  end

  assign memReqAddr = ptrQ;
  assign pass       = passQ;
  assign cause      = causeQ;

endmodule

// File: rtl/lpv_control.sv
`timescale 1ns/1ps
module lpv_control
  import lpv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  flags_s flags,
  input  logic   memReqReady,
  input  logic   memRspValid,
  input  logic   memRspErr,
  output ctrl_s  ctrl,
  output logic   memReqValid,
  output logic   done,
  output logic   awaitRsp
);

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD         = stateQ;
    ctrl.capture   = 1'b0;
    ctrl.setResult = 1'b0;
    ctrl.code      = CAUSE_OK;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.capture = 1'b1;
          stateD       = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.sentinel) begin
          ctrl.setResult = 1'b1;
          ctrl.code      = CAUSE_OK;
          stateD         = ST_DONE;
        end else if (flags.misaligned) begin
          ctrl.setResult = 1'b1;
          ctrl.code      = CAUSE_MISALIGN;
          stateD         = ST_DONE;
        end else if (flags.tooWide) begin
          ctrl.setResult = 1'b1;
          ctrl.code      = CAUSE_WIDE;
          stateD         = ST_DONE;
        end else if (flags.selfRef) begin
          ctrl.setResult = 1'b1;
          ctrl.code      = CAUSE_SELF;
          stateD         = ST_DONE;
        end else begin
          stateD = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          ctrl.setResult = 1'b1;
          if (memRspErr)           ctrl.code = CAUSE_MEMERR;
          else if (flags.revMatch) ctrl.code = CAUSE_OK;
          else                     ctrl.code = CAUSE_REV;
          stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign memReqValid = (stateQ == ST_FETCH);
  assign done        = (stateQ == ST_DONE);
  assign awaitRsp    = (stateQ == ST_WAIT);

endmodule

// File: rtl/link_ptr_validator.sv
`timescale 1ns/1ps
module link_ptr_validator
  import lpv_pkg::*;
#(
  parameter int PTR_W      = 64,
  parameter int REV_W      = 32,
  parameter int PAW_W      = 8,
  parameter int ALIGN_BITS = 12,
  parameter int NARROW_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PTR_W-1:0] linkPtr,
  input  logic [PTR_W-1:0] curPtr,
  input  logic [REV_W-1:0] revId,
  input  logic [PAW_W-1:0] paWidth,
  input  logic             wideMode,
  input  logic             inSmm,
  input  logic             entrySmm,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PTR_W-1:0] memReqAddr,
  input  logic             memRspValid,
  input  logic [REV_W-1:0] memRspData,
  input  logic             memRspErr,
  output logic             done,
  output logic             pass,
  output logic [2:0]       cause
);

  ctrl_s  ctrl;
  flags_s flags;
  logic   awaitRsp;

  lpv_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .flags       (flags),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .ctrl        (ctrl),
    .memReqValid (memReqValid),
    .done        (done),
    .awaitRsp    (awaitRsp)
  );

  lpv_datapath #(
    .PTR_W      (PTR_W),
    .REV_W      (REV_W),
    .PAW_W      (PAW_W),
    .ALIGN_BITS (ALIGN_BITS),
    .NARROW_W   (NARROW_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .linkPtr    (linkPtr),
    .curPtr     (curPtr),
    .revId      (revId),
    .paWidth    (paWidth),
    .wideMode   (wideMode),
    .inSmm      (inSmm),
    .entrySmm   (entrySmm),
    .memRspData (memRspData),
    .flags      (flags),
    .memReqAddr (memReqAddr),
    .pass       (pass),
    .cause      (cause)
  );

endmodule

// File: rtl/lpv_checker.sv
`timescale 1ns/1ps
module lpv_checker #(
  parameter int PTR_W      = 64,
  parameter int ALIGN_BITS = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             pass,
  input logic [2:0]       cause,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PTR_W-1:0] memReqAddr,
  input logic             memRspValid,
  input logic             memRspErr,
  input logic             awaitRsp
);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_pass_matches_cause: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass == (cause == 3'd0)));

  a_r10_cause_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cause <= 3'd5));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  a_r7_single_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  a_r2_aligned_req: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[ALIGN_BITS-1:0] == '0));

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    (awaitRsp && memRspValid && memRspErr) |=> (done && cause == 3'd5));

  a_r12_no_done_with_req: assert property (@(posedge clk) disable iff (!rstN)
    !(done && memReqValid));

endmodule

bind link_ptr_validator lpv_checker #(
  .PTR_W      (PTR_W),
  .ALIGN_BITS (ALIGN_BITS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .done        (done),
  .pass        (pass),
  .cause       (cause),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .memRspErr   (memRspErr),
  .awaitRsp    (awaitRsp)
);

// File: tb/link_ptr_validator_tb.sv
`timescale 1ns/1ps
module link_ptr_validator_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] linkPtr = '0;
  logic [63:0] curPtr = '0;
  logic [31:0] revId = '0;
  logic [7:0]  paWidth = '0;
  logic        wideMode = 1'b0;
  logic        inSmm = 1'b0;
  logic        entrySmm = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        done;
  logic        pass;
  logic [2:0]  cause;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  link_ptr_validator u_dut (
    .clk(clk), .rstN(rstN), .start(start), .linkPtr(linkPtr), .curPtr(curPtr),
    .revId(revId), .paWidth(paWidth), .wideMode(wideMode), .inSmm(inSmm),
    .entrySmm(entrySmm), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspErr(memRspErr), .done(done), .pass(pass), .cause(cause)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runCheck(input string tag, input logic [63:0] ptr,
                          input logic [63:0] cur, input logic [31:0] rev,
                          input logic [7:0] pa, input logic wide,
                          input logic smm, input logic entSmm,
                          input int readyDelay, input logic rspErr,
                          input logic badData, input logic expFetch,
                          input logic [2:0] expCause, input logic pokeBusy);
    int  waitCnt = 0;
    int  reqCnt = 0;
    int  doneCyc = 0;
    bit  accepted = 0;
    bit  rspSent = 0;
    bit  sawDone = 0;
    bit  addrOk = 1;
    @(negedge clk);
    linkPtr = ptr; curPtr = cur; revId = rev; paWidth = pa;
    wideMode = wide; inSmm = smm; entrySmm = entSmm; start = 1'b1;
    for (int cyc = 1; cyc <= 60 && !sawDone; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      memRspValid = 1'b0;
      memReqReady = 1'b0;
      if (pokeBusy && cyc == 2) begin
        start = 1'b1;
        linkPtr = ptr ^ 64'h1000;
      end
      if (done) begin
        sawDone = 1;
        doneCyc = cyc;
      end else if (accepted) begin
        if (memReqValid) reqCnt++;
        if (!rspSent) begin
          memRspValid = 1'b1;
          memRspData = badData ? (rev ^ 32'h1) : rev;
          memRspErr = rspErr;
          rspSent = 1;
        end
      end else if (memReqValid) begin
        if (memReqAddr !== ptr) addrOk = 0;
        if (waitCnt >= readyDelay) begin
          memReqReady = 1'b1;
          accepted = 1;
          reqCnt++;
        end else begin
          waitCnt++;
        end
      end
    end
    chk(tag, "done seen", 64'(sawDone), 64'd1);
    chk(tag, "cause", 64'(cause), 64'(expCause));
    chk(tag, "pass", 64'(pass), 64'(expCause == 3'd0));
    chk(tag, "request count", 64'(reqCnt), 64'(expFetch));
    if (expFetch) chk(tag, "request address held", 64'(addrOk), 64'd1);
    else          chk(tag, "format latency", 64'(doneCyc), 64'd2);
    @(negedge clk);
    chk("R10", "done width", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10", "cause held", 64'(cause), 64'(expCause));
    chk("R11", "no extra activity", 64'({done, memReqValid}), 64'd0);
  endtask

  task automatic testReset();
    chk("R12", "done after reset", 64'(done), 64'd0);
    chk("R12", "pass after reset", 64'(pass), 64'd0);
    chk("R12", "req after reset", 64'(memReqValid), 64'd0);
    chk("R12", "cause after reset", 64'(cause), 64'd0);
  endtask

  task automatic testSentinel();
    runCheck("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h11, 8'd4,
             1, 0, 0, 0, 0, 0, 0, 3'd0, 0);
  endtask

  task automatic testAlign();
    runCheck("R2", 64'h1234, 64'h0, 32'h5, 8'd48, 1, 0, 0, 0, 0, 0, 0, 3'd1, 0);
    runCheck("R2", 64'h0000_0000_0010_0800, 64'h0, 32'h5, 8'd48, 1, 0, 0, 0, 0, 0, 0, 3'd1, 0);
  endtask

  task automatic testWide();
    runCheck("R3", 64'h0000_0100_0000_0000, 64'h0, 32'h9, 8'd40, 1, 0, 0, 0, 0, 0, 0, 3'd2, 0);
    runCheck("R3", 64'h0000_00FF_FFFF_F000, 64'h0, 32'hA5A5_0001, 8'd40, 1, 0, 0, 1, 0, 0, 1, 3'd0, 0);
    runCheck("R3", 64'h8000_0000_0000_0000, 64'h0, 32'h77, 8'd200, 1, 0, 0, 0, 0, 0, 1, 3'd0, 0);
    runCheck("R3", 64'h8000_0000_0000_0000, 64'h0, 32'h78, 8'd63, 1, 0, 0, 0, 0, 0, 0, 3'd2, 0);
  endtask

  task automatic testNarrow();
    runCheck("R4", 64'h0000_0001_0000_0000, 64'h0, 32'h3, 8'd64, 0, 0, 0, 0, 0, 0, 0, 3'd2, 0);
    runCheck("R4", 64'h0000_0000_FFFF_F000, 64'h0, 32'h3, 8'd8, 0, 0, 0, 2, 0, 0, 1, 3'd0, 0);
  endtask

  task automatic testSelf();
    runCheck("R5", 64'h0000_0000_0004_0000, 64'h0000_0000_0004_0000, 32'h1, 8'd36,
             1, 0, 0, 0, 0, 0, 0, 3'd3, 0);
    runCheck("R5", 64'h0000_0000_0004_0000, 64'h0000_0000_0004_0000, 32'h1, 8'd36,
             1, 1, 0, 0, 0, 0, 1, 3'd0, 0);
    runCheck("R5", 64'h0000_0000_0004_0000, 64'h0000_0000_0004_0000, 32'h1, 8'd36,
             1, 1, 1, 0, 0, 0, 0, 3'd3, 0);
  endtask

  task automatic testPriority();
    runCheck("R6", 64'hF000_0000_0000_0010, 64'hF000_0000_0000_0010, 32'h2, 8'd36,
             1, 0, 0, 0, 0, 0, 0, 3'd1, 0);
    runCheck("R6", 64'hF000_0000_0000_0000, 64'hF000_0000_0000_0000, 32'h2, 8'd36,
             1, 0, 0, 0, 0, 0, 0, 3'd2, 0);
  endtask

  task automatic testFetch();
    runCheck("R7", 64'h0000_0000_0ABC_D000, 64'h0, 32'hCAFE_0042, 8'd40, 1, 0, 0, 3, 0, 0, 1, 3'd0, 0);
    runCheck("R8", 64'h0000_0000_0ABC_D000, 64'h0, 32'hCAFE_0042, 8'd40, 1, 0, 0, 2, 0, 1, 1, 3'd4, 0);
    runCheck("R9", 64'h0000_0000_0ABC_D000, 64'h0, 32'hCAFE_0042, 8'd40, 1, 0, 0, 1, 1, 0, 1, 3'd5, 0);
  endtask

  task automatic testBusyStart();
    runCheck("R11", 64'h0000_0000_0123_4000, 64'h0, 32'h0BAD_F00D, 8'd40, 1, 0, 0, 4, 0, 0, 1, 3'd0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSentinel();
    testAlign();
    testWide();
    testNarrow();
    testSelf();
    testPriority();
    testFetch();
    testBusyStart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule